// File: doc/BRIEF.md
# Flash Command Decoder with Two-Cycle Launch

This block sits between a host bus and the internal operation sequencer of a flash device. Each bus write carries a command byte in the low eight bits of its data. Single-cycle commands choose what later bus reads return: array contents, identifier codes or the status word. They also clear the sticky error bits, or ask the sequencer to pause or continue. An altering operation starts only from an exact setup/confirm pair. These operations are block erase, word write, setting a block lock bit, setting the permanent lock bit and clearing all block lock bits. When a pair is accepted, the decoder issues a one-cycle start pulse and holds the target address and data for the sequencer.

When a confirm byte is wrong, the decoder does not drop it quietly. It records the failure in the status word, and in every case it switches reads to the status word, so the host can see the outcome. The status value a host reads is frozen on the read strobe's leading edge. A new value is captured only after the strobe has gone inactive again. The sequencer's busy, suspend and error reports are inputs. Protection policy is left to the sequencer.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, readSel is 0 (array), no start or request pulse is active, and a status read returns 80h (ready, no error bits) while the sequencer is idle.
- R2: The command FFh selects array reads (readSel 0), 90h selects identifier reads (readSel 1), and 70h selects status reads (readSel 2). The change is visible in the cycle after the write.
- R3: FFh is ignored while seqBusy is high and neither suspend input is high. While suspended, it is honoured.
- R4: A 20h write followed by a D0h write whose address lies in the same block (address bits above BLK_BITS equal) pulses startErase. opAddr takes the confirm address, and readSel becomes 2.
- R5: An erase setup followed by any other byte, or by D0h in a different block, produces no start and sets status bits 5 and 4. That next write is consumed, so a following lone D0h acts as a resume.
- R6: A 40h or 10h write followed by any write pulses startWrite. opAddr and opData take that second write's address and full data word.
- R7: After 60h, a second byte of 01h pulses startLockSet, F1h pulses startPermLock, and D0h pulses startLockClear. Each latches opAddr.
- R8: After 60h, any other second byte produces no start, sets status bits 5 and 4, and leaves readSel at 2.
- R9: The command 50h clears status bits 5, 4, 3 and 1, except while seqEraseSusp or seqWriteSusp is high, when it has no effect.
- R10: A one-cycle seqErr pulse sets a sticky status bit: seqErr[0] sets bit 1, [1] sets bit 3, [2] sets bit 4 and [3] sets bit 5. The bit holds until it is cleared.
- R11: statusOut is loaded only in the cycle after rdEn rises, and it keeps its value while rdEn stays high.
- R12: The status word has bit 7 = not busy or suspended, bit 6 = seqEraseSusp and bit 2 = seqWriteSusp. B0h pulses suspendReq, and a lone D0h pulses resumeReq. Both set readSel to 2.
- R13: At most one start pulse is active in any cycle. Each start pulse lasts one cycle and follows a sampled write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | One-cycle bus write strobe |
| wrAddr | input | AW | Write address |
| wrData | input | DW | Write data; command byte in bits 7:0 |
| rdEn | input | 1 | Bus read strobe, active high level |
| seqBusy | input | 1 | Sequencer running an operation |
| seqEraseSusp | input | 1 | Erase is suspended |
| seqWriteSusp | input | 1 | Word write is suspended |
| seqErr | input | 4 | One-cycle error reports from the sequencer |
| readSel | output | 2 | Read source: 0 array, 1 identifier, 2 status |
| startErase | output | 1 | Erase launch pulse |
| startWrite | output | 1 | Word write launch pulse |
| startLockSet | output | 1 | Block lock set launch pulse |
| startPermLock | output | 1 | Permanent lock launch pulse |
| startLockClear | output | 1 | Lock clear launch pulse |
| suspendReq | output | 1 | Suspend request pulse |
| resumeReq | output | 1 | Resume request pulse |
| opAddr | output | AW | Latched operation address |
| opData | output | DW | Latched operation data |
| statusOut | output | 8 | Captured status word |

## Verification
On every cycle, the assertions check four things. Start pulses are exclusive, last one cycle and follow a write. Any launch leaves reads on status. An array select never appears while the sequencer runs unsuspended. The captured status word never moves except after a rising read strobe. The bench scenarios are the only place where the command bytes themselves are checked. These cover the setup/confirm pairing, the block match on erase, each lock variant, a bad confirm being consumed and its error bits, sticky error bits and their clear being blocked during suspend, and the exact status values read.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

  typedef enum logic [1:0] {
    RD_ARRAY  = 2'd0,
    RD_IDENT  = 2'd1,
    RD_STATUS = 2'd2
  } rdMode_e;

  typedef enum logic [1:0] {
    PEND_NONE  = 2'd0,
    PEND_ERASE = 2'd1,
    PEND_WRITE = 2'd2,
    PEND_LOCK  = 2'd3
  } pend_e;

  typedef struct packed {
    logic goArray;
    logic goIdent;
    logic goStatus;
    logic latchSetup;
    logic latchOp;
    logic clrErr;
    logic cmdErr;
  } ctrlStb_t;

  localparam logic [7:0] CMD_ARRAY   = 8'hFF;
  localparam logic [7:0] CMD_IDENT   = 8'h90;
  localparam logic [7:0] CMD_STATUS  = 8'h70;
  localparam logic [7:0] CMD_CLEAR   = 8'h50;
  localparam logic [7:0] CMD_PAUSE   = 8'hB0;
  localparam logic [7:0] CMD_GO      = 8'hD0;
  localparam logic [7:0] CMD_ERASE   = 8'h20;
  localparam logic [7:0] CMD_WRITE_A = 8'h40;
  localparam logic [7:0] CMD_WRITE_B = 8'h10;
  localparam logic [7:0] CMD_LOCK    = 8'h60;
  localparam logic [7:0] SUB_LOCKSET = 8'h01;
  localparam logic [7:0] SUB_PERM    = 8'hF1;

  // sticky error positions inside the status word, index 0..3
  localparam int ERR_BITS = 4;

endpackage

// File: rtl/fcd_ctrl.sv
module fcd_ctrl
  import fcd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [7:0] cmdByte,
  input  logic       sameBlock,
  input  logic       seqBusy,
  input  logic       seqSuspended,
  output ctrlStb_t   stb,
  output logic       startErase,
  output logic       startWrite,
  output logic       startLockSet,
  output logic       startPermLock,
  output logic       startLockClear,
  output logic       suspendReq,
  output logic       resumeReq
);

  pend_e pendQ, pendNext;
  logic  nErase, nWrite, nLockSet, nPerm, nLockClr, nSusp, nResume;

  always_comb begin
    stb      = '0;
    pendNext = pendQ;
    nErase   = 1'b0;
    nWrite   = 1'b0;
    nLockSet = 1'b0;
    nPerm    = 1'b0;
    nLockClr = 1'b0;
    nSusp    = 1'b0;
    nResume  = 1'b0;
    if (wrEn) begin
      case (pendQ)
        PEND_ERASE: begin
          pendNext     = PEND_NONE;
          stb.goStatus = 1'b1;
          if (cmdByte == CMD_GO && sameBlock) begin
            stb.latchOp = 1'b1;
            nErase      = 1'b1;
          end else begin
            stb.cmdErr = 1'b1;
          end
        end
        PEND_WRITE: begin
          pendNext     = PEND_NONE;
          stb.goStatus = 1'b1;
          stb.latchOp  = 1'b1;
          nWrite       = 1'b1;
        end
        PEND_LOCK: begin
          pendNext     = PEND_NONE;
          stb.goStatus = 1'b1;
          case (cmdByte)
            SUB_LOCKSET: begin stb.latchOp = 1'b1; nLockSet = 1'b1; end
            SUB_PERM:    begin stb.latchOp = 1'b1; nPerm    = 1'b1; end
            CMD_GO:      begin stb.latchOp = 1'b1; nLockClr = 1'b1; end
            default:     stb.cmdErr = 1'b1;
          endcase
        end
        default: begin
          case (cmdByte)
            CMD_ARRAY:  stb.goArray  = !(seqBusy && !seqSuspended);
            CMD_IDENT:  stb.goIdent  = 1'b1;
            CMD_STATUS: stb.goStatus = 1'b1;
            CMD_CLEAR:  stb.clrErr   = !seqSuspended;
            CMD_PAUSE:  begin nSusp   = 1'b1; stb.goStatus = 1'b1; end
            CMD_GO:     begin nResume = 1'b1; stb.goStatus = 1'b1; end
            CMD_ERASE: begin
              pendNext       = PEND_ERASE;
              stb.latchSetup = 1'b1;
              stb.goStatus   = 1'b1;
            end
            CMD_WRITE_A, CMD_WRITE_B: begin
              pendNext     = PEND_WRITE;
              stb.goStatus = 1'b1;
            end
            CMD_LOCK: begin
              pendNext     = PEND_LOCK;
              stb.goStatus = 1'b1;
            end
            default: ;
          endcase
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ          <= PEND_NONE;
      startErase     <= 1'b0;
      startWrite     <= 1'b0;
      startLockSet   <= 1'b0;
      startPermLock  <= 1'b0;
      startLockClear <= 1'b0;
      suspendReq     <= 1'b0;
      resumeReq      <= 1'b0;
    end else begin
      pendQ          <= pendNext;
      startErase     <= nErase;
      startWrite     <= nWrite;
      startLockSet   <= nLockSet;
      startPermLock  <= nPerm;
      startLockClear <= nLockClr;
      suspendReq     <= nSusp;
      resumeReq      <= nResume;
    end
  end

endmodule

// File: rtl/fcd_datapath.sv
module fcd_datapath
  import fcd_pkg::*;
#(
  parameter int AW       = 20,
  parameter int DW       = 16,
  parameter int BLK_BITS = 15
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStb_t            stb,
  input  logic [AW-1:0]       wrAddr,
  input  logic [DW-1:0]       wrData,
  input  logic                rdEn,
  input  logic                seqBusy,
  input  logic                seqEraseSusp,
  input  logic                seqWriteSusp,
  input  logic [ERR_BITS-1:0] seqErr,
  output logic                sameBlock,
  output logic [1:0]          readSel,
  output logic [AW-1:0]       opAddr,
  output logic [DW-1:0]       opData,
  output logic [7:0]          statusOut
);

  localparam int TAG_W = AW - BLK_BITS;
  localparam logic [ERR_BITS-1:0] CMD_ERR_MASK = 4'b1100;

  rdMode_e             modeQ;
  logic [TAG_W-1:0]    setupTag;
  logic [ERR_BITS-1:0] errQ, errNext;
  logic                rdPrev;
  logic                ready;
  logic [7:0]          liveStatus;

  assign sameBlock = (wrAddr[AW-1:BLK_BITS] == setupTag);
  assign readSel   = modeQ;
  assign ready     = !seqBusy || seqEraseSusp || seqWriteSusp;

  always_comb begin
    errNext = stb.clrErr ? '0 : errQ;
    errNext = errNext | seqErr | (stb.cmdErr ? CMD_ERR_MASK : '0);
  end

  assign liveStatus = {ready, seqEraseSusp, errQ[3], errQ[2], errQ[1],
                       seqWriteSusp, errQ[0], 1'b0};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ     <= RD_ARRAY;
      setupTag  <= '0;
      errQ      <= '0;
      rdPrev    <= 1'b0;
      opAddr    <= '0;
      opData    <= '0;
      statusOut <= '0;
    end else begin
      if (stb.goArray)      modeQ <= RD_ARRAY;
      else if (stb.goIdent) modeQ <= RD_IDENT;
      else if (stb.goStatus) modeQ <= RD_STATUS;
      if (stb.latchSetup) setupTag <= wrAddr[AW-1:BLK_BITS];
      if (stb.latchOp) begin
        opAddr <= wrAddr;
        opData <= wrData;
      end
      errQ   <= errNext;
      rdPrev <= rdEn;
      if (rdEn && !rdPrev) statusOut <= liveStatus;
    end
  end

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int AW       = 20,
  parameter int DW       = 16,
  parameter int BLK_BITS = 15
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic [AW-1:0] wrAddr,
  input  logic [DW-1:0] wrData,
  input  logic          rdEn,
  input  logic          seqBusy,
  input  logic          seqEraseSusp,
  input  logic          seqWriteSusp,
  input  logic [3:0]    seqErr,
  output logic [1:0]    readSel,
  output logic          startErase,
  output logic          startWrite,
  output logic          startLockSet,
  output logic          startPermLock,
  output logic          startLockClear,
  output logic          suspendReq,
  output logic          resumeReq,
  output logic [AW-1:0] opAddr,
  output logic [DW-1:0] opData,
  output logic [7:0]    statusOut
);

  ctrlStb_t stb;
  logic     sameBlock;

  fcd_ctrl u_ctrl (
    .clk            (clk),
    .rstN           (rstN),
    .wrEn           (wrEn),
    .cmdByte        (wrData[7:0]),
    .sameBlock      (sameBlock),
    .seqBusy        (seqBusy),
    .seqSuspended   (seqEraseSusp | seqWriteSusp),
    .stb            (stb),
    .startErase     (startErase),
    .startWrite     (startWrite),
    .startLockSet   (startLockSet),
    .startPermLock  (startPermLock),
    .startLockClear (startLockClear),
    .suspendReq     (suspendReq),
    .resumeReq      (resumeReq)
  );

  fcd_datapath #(.AW(AW), .DW(DW), .BLK_BITS(BLK_BITS)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .stb          (stb),
    .wrAddr       (wrAddr),
    .wrData       (wrData),
    .rdEn         (rdEn),
    .seqBusy      (seqBusy),
    .seqEraseSusp (seqEraseSusp),
    .seqWriteSusp (seqWriteSusp),
    .seqErr       (seqErr),
    .sameBlock    (sameBlock),
    .readSel      (readSel),
    .opAddr       (opAddr),
    .opData       (opData),
    .statusOut    (statusOut)
  );

endmodule

// File: rtl/fcd_checker.sv
module fcd_checker (
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic       rdEn,
  input logic       seqBusy,
  input logic       seqEraseSusp,
  input logic       seqWriteSusp,
  input logic [1:0] readSel,
  input logic       startErase,
  input logic       startWrite,
  input logic       startLockSet,
  input logic       startPermLock,
  input logic       startLockClear,
  input logic [7:0] statusOut
);

  logic [4:0] starts;
  assign starts = {startErase, startWrite, startLockSet, startPermLock, startLockClear};

  p_start_onehot_r13: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(starts));

  p_start_single_r13: assert property (@(posedge clk) disable iff (!rstN)
    (starts != 5'd0) |=> (starts == 5'd0));

  p_start_after_write_r13: assert property (@(posedge clk) disable iff (!rstN)
    (starts != 5'd0) |-> $past(wrEn));

  // R4 R6 R7: a launch always leaves reads on the status word
  p_launch_status_r4: assert property (@(posedge clk) disable iff (!rstN)
    (starts != 5'd0) |-> (readSel == 2'd2));

  p_array_blocked_r3: assert property (@(posedge clk) disable iff (!rstN)
    (readSel != 2'd0 && seqBusy && !seqEraseSusp && !seqWriteSusp) |=> (readSel != 2'd0));

  p_capture_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    !$rose(rdEn) |=> $stable(statusOut));

endmodule

bind flash_cmd_decoder fcd_checker u_fcd_checker (
  .clk            (clk),
  .rstN           (rstN),
  .wrEn           (wrEn),
  .rdEn           (rdEn),
  .seqBusy        (seqBusy),
  .seqEraseSusp   (seqEraseSusp),
  .seqWriteSusp   (seqWriteSusp),
  .readSel        (readSel),
  .startErase     (startErase),
  .startWrite     (startWrite),
  .startLockSet   (startLockSet),
  .startPermLock  (startPermLock),
  .startLockClear (startLockClear),
  .statusOut      (statusOut)
);

// File: tb/flash_cmd_decoder_bench.sv
`timescale 1ns/1ps
module flash_cmd_decoder_bench;

  localparam int AW = 20;
  localparam int DW = 16;

  localparam int K_MODE   = 0;
  localparam int K_START  = 1;
  localparam int K_ADDR   = 2;
  localparam int K_DATA   = 3;
  localparam int K_STATUS = 4;

  // start vector: {erase, write, lockSet, perm, lockClear, suspend, resume}
  localparam logic [6:0] S_NONE  = 7'b0000000;
  localparam logic [6:0] S_ERASE = 7'b1000000;
  localparam logic [6:0] S_WRITE = 7'b0100000;
  localparam logic [6:0] S_LSET  = 7'b0010000;
  localparam logic [6:0] S_PERM  = 7'b0001000;
  localparam logic [6:0] S_LCLR  = 7'b0000100;
  localparam logic [6:0] S_SUSP  = 7'b0000010;
  localparam logic [6:0] S_RES   = 7'b0000001;

  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       req;
  } item_t;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wrEn = 1'b0;
  logic [AW-1:0] wrAddr = '0;
  logic [DW-1:0] wrData = '0;
  logic          rdEn = 1'b0;
  logic          seqBusy = 1'b0;
  logic          seqEraseSusp = 1'b0;
  logic          seqWriteSusp = 1'b0;
  logic [3:0]    seqErr = '0;
  logic [1:0]    readSel;
  logic          startErase, startWrite, startLockSet, startPermLock, startLockClear;
  logic          suspendReq, resumeReq;
  logic [AW-1:0] opAddr;
  logic [DW-1:0] opData;
  logic [7:0]    statusOut;

  item_t q[$];
  event  chk;
  int    nCmp = 0;
  int    nBad = 0;
  bit    done = 1'b0;

  always #2.5 clk = ~clk;

  flash_cmd_decoder u_flash_cmd_decoder (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdEn(rdEn), .seqBusy(seqBusy), .seqEraseSusp(seqEraseSusp),
    .seqWriteSusp(seqWriteSusp), .seqErr(seqErr), .readSel(readSel),
    .startErase(startErase), .startWrite(startWrite), .startLockSet(startLockSet),
    .startPermLock(startPermLock), .startLockClear(startLockClear),
    .suspendReq(suspendReq), .resumeReq(resumeReq), .opAddr(opAddr),
    .opData(opData), .statusOut(statusOut)
  );

  // monitor: pops expected items and compares them with the outputs
  initial begin
    forever begin
      @(chk);
      while (q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = q.pop_front();
        case (it.kind)
          K_MODE:   act = {30'd0, readSel};
          K_START:  act = {25'd0, startErase, startWrite, startLockSet, startPermLock,
                           startLockClear, suspendReq, resumeReq};
          K_ADDR:   act = {12'd0, opAddr};
          K_DATA:   act = {16'd0, opData};
          default:  act = {24'd0, statusOut};
        endcase
        nCmp++;
        if (act !== it.exp) begin
          nBad++;
          $display("FAIL %s kind=%0d actual=%0h expected=%0h", it.req, it.kind, act, it.exp);
        end
      end
    end
  end

  task automatic expect_item(input int kind, input logic [31:0] exp, input string req);
    item_t it;
    it.kind = kind;
    it.exp  = exp;
    it.req  = req;
    q.push_back(it);
  endtask

  task automatic flush();
    -> chk;
    #0;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    wrAddr = a;
    wrData = d;
    wrEn   = 1'b1;
    @(negedge clk);
    wrEn   = 1'b0;
  endtask

  task automatic rd_status(input logic [7:0] exp, input string req);
    rdEn = 1'b1;
    @(negedge clk);
    expect_item(K_STATUS, {24'd0, exp}, req);
    flush();
    rdEn = 1'b0;
    @(negedge clk);
  endtask

  task automatic idle_check(input string req);
    @(negedge clk);
    expect_item(K_START, {25'd0, S_NONE}, req);
    flush();
  endtask

  initial begin
    #400000;
    if (!done) begin
      nBad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    expect_item(K_MODE, 32'd0, "R1");
    expect_item(K_START, {25'd0, S_NONE}, "R1");
    flush();
    rd_status(8'h80, "R1");

    // R2 read mode selection
    wr(20'h00000, 16'h0090); expect_item(K_MODE, 32'd1, "R2"); flush();
    wr(20'h00000, 16'h0070); expect_item(K_MODE, 32'd2, "R2"); flush();
    wr(20'h00000, 16'h00FF); expect_item(K_MODE, 32'd0, "R2"); flush();

    // R4 erase pair within one block
    wr(20'h08010, 16'h0020);
    expect_item(K_MODE, 32'd2, "R4");
    expect_item(K_START, {25'd0, S_NONE}, "R4");
    flush();
    wr(20'h08123, 16'h00D0);
    expect_item(K_START, {25'd0, S_ERASE}, "R4");
    expect_item(K_ADDR, 32'h08123, "R4");
    flush();
    idle_check("R13");

    // R5 bad confirm byte, then a lone D0h is a resume
    wr(20'h00000, 16'h00FF);
    wr(20'h10000, 16'h0020);
    wr(20'h10000, 16'h00FF);
    expect_item(K_START, {25'd0, S_NONE}, "R5");
    expect_item(K_MODE, 32'd2, "R5");
    flush();
    rd_status(8'hB0, "R5");
    wr(20'h10000, 16'h00D0);
    expect_item(K_START, {25'd0, S_RES}, "R5");
    flush();
    wr(20'h00000, 16'h0050);
    rd_status(8'h80, "R9");

    // R5 confirm in another block
    wr(20'h10000, 16'h0020);
    wr(20'h18000, 16'h00D0);
    expect_item(K_START, {25'd0, S_NONE}, "R5");
    flush();
    rd_status(8'hB0, "R5");
    wr(20'h00000, 16'h0050);

    // R6 word write with both setup codes
    wr(20'h00ABC, 16'h0040);
    expect_item(K_START, {25'd0, S_NONE}, "R6");
    flush();
    wr(20'h00ABC, 16'h5A5A);
    expect_item(K_START, {25'd0, S_WRITE}, "R6");
    expect_item(K_ADDR, 32'h00ABC, "R6");
    expect_item(K_DATA, 32'h5A5A, "R6");
    flush();
    wr(20'h00000, 16'h0010);
    wr(20'h7FFFF, 16'h0060);
    expect_item(K_START, {25'd0, S_WRITE}, "R6");
    expect_item(K_ADDR, 32'h7FFFF, "R6");
    expect_item(K_DATA, 32'h0060, "R6");
    flush();

    // R7 lock variants
    wr(20'h28000, 16'h0060);
    wr(20'h28004, 16'h0001);
    expect_item(K_START, {25'd0, S_LSET}, "R7");
    expect_item(K_ADDR, 32'h28004, "R7");
    flush();
    wr(20'h00000, 16'h0060);
    wr(20'h00001, 16'h00F1);
    expect_item(K_START, {25'd0, S_PERM}, "R7");
    expect_item(K_ADDR, 32'h00001, "R7");
    flush();
    wr(20'h00000, 16'h0060);
    wr(20'h00002, 16'h00D0);
    expect_item(K_START, {25'd0, S_LCLR}, "R7");
    flush();

    // R8 lock with unknown second byte
    wr(20'h00000, 16'h00FF);
    wr(20'h00000, 16'h0060);
    wr(20'h00000, 16'h0077);
    expect_item(K_START, {25'd0, S_NONE}, "R8");
    expect_item(K_MODE, 32'd2, "R8");
    flush();
    rd_status(8'hB0, "R8");

    // R3 array blocked while busy; R12 suspend/resume
    seqBusy = 1'b1;
    wr(20'h00000, 16'h00FF);
    expect_item(K_MODE, 32'd2, "R3");
    flush();
    rd_status(8'h30, "R12");
    wr(20'h00000, 16'h00B0);
    expect_item(K_START, {25'd0, S_SUSP}, "R12");
    flush();
    seqEraseSusp = 1'b1;
    rd_status(8'hF0, "R12");
    wr(20'h00000, 16'h0050);
    rd_status(8'hF0, "R9");
    wr(20'h00000, 16'h00FF);
    expect_item(K_MODE, 32'd0, "R3");
    flush();
    wr(20'h00000, 16'h00D0);
    expect_item(K_START, {25'd0, S_RES}, "R12");
    expect_item(K_MODE, 32'd2, "R12");
    flush();
    seqEraseSusp = 1'b0;
    wr(20'h00000, 16'h0050);
    rd_status(8'h00, "R9");
    seqWriteSusp = 1'b1;
    rd_status(8'h84, "R12");
    seqWriteSusp = 1'b0;
    seqBusy = 1'b0;

    // R10 sticky sequencer errors
    seqErr = 4'b0011;
    @(negedge clk);
    seqErr = 4'b0000;
    rd_status(8'h8A, "R10");
    repeat (4) @(negedge clk);
    rd_status(8'h8A, "R10");
    wr(20'h00000, 16'h0050);
    rd_status(8'h80, "R10");

    // R11 capture holds while rdEn stays high
    rdEn = 1'b1;
    @(negedge clk);
    seqErr = 4'b1000;
    @(negedge clk);
    seqErr = 4'b0000;
    repeat (2) @(negedge clk);
    expect_item(K_STATUS, 32'h80, "R11");
    flush();
    rdEn = 1'b0;
    @(negedge clk);
    rd_status(8'hA0, "R11");

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule